// File: doc/BRIEF.md
# Daisy-Chain Serial Control Word Router

This block is the serial front end of one node in a chain of converter nodes that share a single host serial link. Each node takes 16-bit frames from its upstream neighbour on a one-bit data line with a frame sync. It either keeps a frame for itself or passes it on to the next node in the chain, or back to the host.

In program mode every frame is a control word. A word whose 3-bit node-address field is zero belongs to this node. It writes either the node's own mode register or an external register through a one-cycle write strobe. A word with any other address has that field decremented by one and goes out on the serial output in the next frame slot. In data mode the node does not look at addresses. It counts frame syncs from a sample-period tick and keeps the frame whose position in the sample period equals its programmed slot number, presenting that word with a one-cycle valid strobe. A mixed mode lets control and data frames share the link by means of a flag bit.

Top module: `chain_ctrl_router`

## Requirements
- R1: Frames are 16 bits, sent MSB first. The frame sync is high for one cycle, in the same cycle as the MSB. Control word fields: bit 15 is the control flag, bit 14 is write (1) or read (0), bits 13:11 are the node address, bits 10:8 are the register select, and bits 7:0 are the data.
- R2: After reset the mode register `cra_o` reads 0, which is program mode. `dac_valid_o`, `reg_we_o` and `sdofs_o` are low.
- R3: In program mode, a write word with address 0 and register select 0 loads bits 7:0 into `cra_o`. A write word with address 0 and a non-zero register select gives one `reg_we_o` pulse carrying that select and that data.
- R4: A read word (bit 14 = 0) with address 0 changes nothing: no `reg_we_o` pulse, no change to `cra_o`, and nothing on the serial output.
- R5: In program mode, a word with a non-zero address is sent on `sdo_o` in the next input frame slot with its address decremented by one and every other bit unchanged. `sdofs_o` is high with its MSB, one cycle after the input frame sync.
- R6: Mode register bit 0 selects data (1) or program (0) mode. Bit 1 selects mixed mode, and bits 4:2 hold the node's slot number. With bit 0 = 1 and bit 1 = 0, every frame is data: control words have no effect on `cra_o`, `reg_we_o` or `sdo_o`.
- R7: In data mode, frame syncs are counted from 0 starting at each `sample_tick_i`. Only the frame whose index equals bits 4:2 of the mode register appears on `dac_data_o`, with a single-cycle `dac_valid_o` pulse.
- R8: The frame counter saturates at 8, so frames beyond the eighth in a sample period are never captured.
- R9: In mixed mode (bits 1:0 = 11), frames with bit 15 = 1 act as control words as in program mode. Frames with bit 15 = 0 are data frames handled as in R7, and every frame sync advances the frame count.
- R10: Writing the mode register with bit 7 = 1 clears it to 0 (program mode). Frames that complete during the following 4 cycles are discarded, as are frames that complete during the 4 cycles after a hardware reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sdi_i | input | 1 | Serial data in, MSB first |
| sdifs_i | input | 1 | Input frame sync, high with the MSB |
| sample_tick_i | input | 1 | Sample-period boundary; restarts the frame count |
| sdo_o | output | 1 | Serial data out for forwarded words |
| sdofs_o | output | 1 | Output frame sync, high with the MSB |
| cra_o | output | 8 | Mode register contents |
| reg_we_o | output | 1 | External register write strobe |
| reg_addr_o | output | 3 | External register select |
| reg_wdata_o | output | 8 | External register write data |
| dac_data_o | output | 16 | Captured data word for this node |
| dac_valid_o | output | 1 | One-cycle strobe for `dac_data_o` |

## Verification
Forwarding is tried with every non-zero address against every register select, using write words with data that depends on both. This separates a wrong decrement, a field bleeding into its neighbours, and a lost bit in the serializer. Capture is swept over all eight slot numbers with ten frames per sample period, each frame tagged with its own index. That shows off-by-one counting, extra captures, and the saturation past eight frames. Local writes, reads and mixed traffic then test the control flag, the write/read bit and the select decode. A control word sent in pure data mode checks that the mode register stays locked.

// File: rtl/chain_pkg.sv
package chain_pkg;
  localparam int WORD_W  = 16;
  localparam int ADDR_W  = 3;
  localparam int RSEL_W  = 3;
  localparam int DATA_W  = 8;

  localparam int CRA_DATA  = 0;
  localparam int CRA_MIXED = 1;
  localparam int CRA_SLOT  = 2;
  localparam int CRA_SRST  = 7;

  typedef struct packed {
    logic              ctrl;
    logic              wr;
    logic [ADDR_W-1:0] node;
    logic [RSEL_W-1:0] rsel;
    logic [DATA_W-1:0] data;
  } ctrl_word_t;
endpackage

// File: rtl/chain_rx.sv
module chain_rx
  import chain_pkg::*;
#(
  parameter int FS_SAT = 8,
  localparam int FS_W  = $clog2(FS_SAT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sdi_i,
  input  logic              sdifs_i,
  input  logic              sample_tick_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic [FS_W-1:0]   idx_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
  localparam logic [FS_W-1:0]  SAT  = FS_W'(FS_SAT);

  logic [CNT_W-1:0] bit_cnt;
  logic             active;
  logic [FS_W-1:0]  fs_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o  <= '0;
      valid_o <= 1'b0;
      bit_cnt <= '0;
      active  <= 1'b0;
      idx_o   <= '0;
    end else begin
      valid_o <= 1'b0;
      if (sdifs_i) begin
        word_o  <= {word_o[WORD_W-2:0], sdi_i};
        bit_cnt <= CNT_W'(1);
        active  <= 1'b1;
        idx_o   <= sample_tick_i ? '0 : fs_cnt;
      end else if (active) begin
        word_o <= {word_o[WORD_W-2:0], sdi_i};
        if (bit_cnt == LAST) begin
          valid_o <= 1'b1;
          active  <= 1'b0;
          bit_cnt <= '0;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  // frame-sync counter per sample period, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      fs_cnt <= '0;
    else if (sample_tick_i)           fs_cnt <= sdifs_i ? FS_W'(1) : '0;
    else if (sdifs_i && fs_cnt != SAT) fs_cnt <= fs_cnt + 1'b1;
  end
endmodule

// File: rtl/chain_dec.sv
module chain_dec
  import chain_pkg::*;
#(
  parameter int RST_CYC = 4,
  parameter int FS_SAT  = 8,
  localparam int FS_W   = $clog2(FS_SAT + 1),
  localparam int RC_W   = $clog2(RST_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              valid_i,
  input  logic [FS_W-1:0]   idx_i,
  output logic [DATA_W-1:0] cra_o,
  output logic              busy_o,
  output logic              reg_we_o,
  output logic [RSEL_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic [WORD_W-1:0] dac_data_o,
  output logic              dac_valid_o,
  output logic              fwd_v_o,
  output logic [WORD_W-1:0] fwd_word_o
);
  ctrl_word_t       cw;
  logic             is_ctrl;
  logic             take;
  logic [RC_W-1:0]  rst_cnt;
  logic [ADDR_W-1:0] slot;

  assign cw      = ctrl_word_t'(word_i);
  assign busy_o  = (rst_cnt != '0);
  assign slot    = cra_o[CRA_SLOT +: ADDR_W];
  assign is_ctrl = !cra_o[CRA_DATA] || (cra_o[CRA_MIXED] && cw.ctrl);
  assign take    = valid_i && !busy_o;

  assign fwd_v_o    = take && is_ctrl && (cw.node != '0);
  assign fwd_word_o = {cw.ctrl, cw.wr, cw.node - 1'b1, cw.rsel, cw.data};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cra_o       <= '0;
      rst_cnt     <= RC_W'(RST_CYC);
      reg_we_o    <= 1'b0;
      reg_addr_o  <= '0;
      reg_wdata_o <= '0;
      dac_data_o  <= '0;
      dac_valid_o <= 1'b0;
    end else begin
      reg_we_o    <= 1'b0;
      dac_valid_o <= 1'b0;
      if (busy_o) rst_cnt <= rst_cnt - 1'b1;
      if (take) begin
        if (is_ctrl) begin
          if (cw.node == '0 && cw.wr) begin
            if (cw.rsel == '0) begin
              if (cw.data[CRA_SRST]) begin
                cra_o   <= '0;
                rst_cnt <= RC_W'(RST_CYC);
              end else begin
                cra_o <= cw.data;
              end
            end else begin
              reg_we_o    <= 1'b1;
              reg_addr_o  <= cw.rsel;
              reg_wdata_o <= cw.data;
            end
          end
        end else if (idx_i == FS_W'(slot)) begin
          dac_data_o  <= word_i;
          dac_valid_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/chain_tx.sv
module chain_tx
  import chain_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              sdo_o,
  output logic              sdofs_o
);
  localparam int CNT_W = $clog2(WORD_W);

  logic              pend;
  logic [WORD_W-1:0] hold;
  logic [WORD_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] nxt;
  logic              start;

  assign nxt   = load_i ? word_i : hold;
  assign start = sync_i && (pend || load_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend    <= 1'b0;
      hold    <= '0;
      sh      <= '0;
      cnt     <= '0;
      sdo_o   <= 1'b0;
      sdofs_o <= 1'b0;
    end else begin
      sdofs_o <= 1'b0;
      if (start) begin
        pend    <= 1'b0;
        sdofs_o <= 1'b1;
        sdo_o   <= nxt[WORD_W-1];
        sh      <= {nxt[WORD_W-2:0], 1'b0};
        cnt     <= CNT_W'(WORD_W - 1);
      end else begin
        if (load_i) begin
          pend <= 1'b1;
          hold <= word_i;
        end
        if (cnt != '0) begin
          sdo_o <= sh[WORD_W-1];
          sh    <= {sh[WORD_W-2:0], 1'b0};
          cnt   <= cnt - 1'b1;
        end else begin
          sdo_o <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/chain_ctrl_router.sv
module chain_ctrl_router
  import chain_pkg::*;
#(
  parameter int RST_CYC = 4,
  parameter int FS_SAT  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sdi_i,
  input  logic              sdifs_i,
  input  logic              sample_tick_i,
  output logic              sdo_o,
  output logic              sdofs_o,
  output logic [7:0]        cra_o,
  output logic              reg_we_o,
  output logic [2:0]        reg_addr_o,
  output logic [7:0]        reg_wdata_o,
  output logic [15:0]       dac_data_o,
  output logic              dac_valid_o
);
  localparam int FS_W = $clog2(FS_SAT + 1);

  logic [WORD_W-1:0] rx_word;
  logic              rx_valid;
  logic [FS_W-1:0]   rx_idx;
  logic              busy;
  logic              fwd_v;
  logic [WORD_W-1:0] fwd_word;

  chain_rx #(.FS_SAT(FS_SAT)) u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sdi_i        (sdi_i),
    .sdifs_i      (sdifs_i),
    .sample_tick_i(sample_tick_i),
    .word_o       (rx_word),
    .valid_o      (rx_valid),
    .idx_o        (rx_idx)
  );

  chain_dec #(.RST_CYC(RST_CYC), .FS_SAT(FS_SAT)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .word_i     (rx_word),
    .valid_i    (rx_valid),
    .idx_i      (rx_idx),
    .cra_o      (cra_o),
    .busy_o     (busy),
    .reg_we_o   (reg_we_o),
    .reg_addr_o (reg_addr_o),
    .reg_wdata_o(reg_wdata_o),
    .dac_data_o (dac_data_o),
    .dac_valid_o(dac_valid_o),
    .fwd_v_o    (fwd_v),
    .fwd_word_o (fwd_word)
  );

  chain_tx u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (sdifs_i),
    .load_i (fwd_v),
    .word_i (fwd_word),
    .sdo_o  (sdo_o),
    .sdofs_o(sdofs_o)
  );
endmodule

// File: rtl/chain_ctrl_router_chk.sv
module chain_ctrl_router_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] cra_o,
  input logic       busy,
  input logic       reg_we_o,
  input logic [2:0] reg_addr_o,
  input logic       dac_valid_o
);
  a_r3_we_nonzero_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> reg_addr_o != 3'd0);

  a_r6_data_mode_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cra_o[0] && !cra_o[1]) |=> $stable(cra_o));

  a_r7_capture_needs_data_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_valid_o |-> $past(cra_o[0]));

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_valid_o |=> !dac_valid_o);

  a_r10_reset_window_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> cra_o == 8'h00);
endmodule

bind chain_ctrl_router chain_ctrl_router_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cra_o      (cra_o),
  .busy       (busy),
  .reg_we_o   (reg_we_o),
  .reg_addr_o (reg_addr_o),
  .dac_valid_o(dac_valid_o)
);

// File: tb/chain_ctrl_router_bench.sv
module chain_ctrl_router_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sdi_i = 1'b0;
  logic        sdifs_i = 1'b0;
  logic        sample_tick_i = 1'b0;
  logic        sdo_o, sdofs_o, reg_we_o, dac_valid_o;
  logic [7:0]  cra_o, reg_wdata_o;
  logic [2:0]  reg_addr_o;
  logic [15:0] dac_data_o;

  int errors = 0;
  int checks = 0;

  int          n_dac = 0, n_we = 0, n_fwd = 0;
  logic [15:0] last_dac = '0, last_fwd = '0;
  logic [2:0]  last_wa = '0;
  logic [7:0]  last_wd = '0;
  int          rx_cnt = 0;
  logic [15:0] rx_acc = '0;

  always #10 clk_i = ~clk_i;

  chain_ctrl_router u_chain_ctrl_router (
    .clk_i(clk_i), .rst_ni(rst_ni), .sdi_i(sdi_i), .sdifs_i(sdifs_i),
    .sample_tick_i(sample_tick_i), .sdo_o(sdo_o), .sdofs_o(sdofs_o),
    .cra_o(cra_o), .reg_we_o(reg_we_o), .reg_addr_o(reg_addr_o),
    .reg_wdata_o(reg_wdata_o), .dac_data_o(dac_data_o), .dac_valid_o(dac_valid_o)
  );

  // output monitors, sampled away from the active edge
  always @(negedge clk_i) begin
    if (dac_valid_o) begin n_dac++; last_dac = dac_data_o; end
    if (reg_we_o) begin n_we++; last_wa = reg_addr_o; last_wd = reg_wdata_o; end
    if (sdofs_o) begin
      rx_cnt = 1; rx_acc = {15'b0, sdo_o};
    end else if (rx_cnt > 0 && rx_cnt < 16) begin
      rx_acc = {rx_acc[14:0], sdo_o};
      rx_cnt++;
      if (rx_cnt == 16) begin n_fwd++; last_fwd = rx_acc; rx_cnt = 0; end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w);
    for (int i = 0; i < 16; i++) begin
      sdifs_i = (i == 0);
      sdi_i   = w[15-i];
      @(negedge clk_i);
    end
    sdifs_i = 1'b0;
    sdi_i   = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic tick();
    sample_tick_i = 1'b1;
    @(negedge clk_i);
    sample_tick_i = 1'b0;
  endtask

  task automatic hw_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (6) @(negedge clk_i);
  endtask

  function automatic logic [15:0] cw(input bit ctl, input bit wr, input int node,
                                     input int rsel, input int data);
    return {ctl, wr, 3'(node), 3'(rsel), 8'(data)};
  endfunction

  localparam logic [15:0] NOP = 16'h8000; // read, node 0: no effect

  initial begin
    fork
      begin
        repeat (150000) @(negedge clk_i);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none

    hw_reset();
    // R2 reset state
    check(cra_o == 8'h00, "R2", "cra after reset", cra_o, 0);
    check(!sdofs_o && !dac_valid_o && !reg_we_o, "R2", "strobes after reset", 1, 0);

    // R5 forwarding sweep, R1 field layout
    for (int a = 1; a < 8; a++) begin
      for (int r = 0; r < 8; r++) begin
        int f0;
        logic [15:0] w;
        f0 = n_fwd;
        w  = cw(1'b1, 1'b1, a, r, (a * 37 + r * 11) & 8'hff);
        send(w);
        send(NOP);
        check(n_fwd == f0 + 1, "R5", "forward count", n_fwd - f0, 1);
        check(last_fwd == {w[15:14], 3'(a - 1), w[10:0]}, "R5", "forwarded word",
              last_fwd, {w[15:14], 3'(a - 1), w[10:0]});
      end
    end
    check(cra_o == 8'h00 && n_we == 0, "R5", "forwarding leaves node state", cra_o, 0);

    // R3 external register writes
    for (int r = 1; r < 8; r++) begin
      int w0;
      w0 = n_we;
      send(cw(1'b1, 1'b1, 0, r, 8'h50 + r));
      check(n_we == w0 + 1 && last_wa == 3'(r) && last_wd == 8'(8'h50 + r),
            "R3", "reg write strobe", {n_we - w0, 5'(last_wa), last_wd},
            {1, 5'(r), 8'(8'h50 + r)});
    end
    send(cw(1'b1, 1'b1, 0, 0, 8'h1c));
    check(cra_o == 8'h1c, "R3", "mode register write", cra_o, 8'h1c);

    // R4 read word has no effect
    begin
      int w0, f0;
      w0 = n_we; f0 = n_fwd;
      send(cw(1'b1, 1'b0, 0, 0, 8'h03));
      send(cw(1'b1, 1'b0, 0, 5, 8'h77));
      send(NOP);
      check(cra_o == 8'h1c && n_we == w0 && n_fwd == f0, "R4", "read ignored",
            cra_o, 8'h1c);
    end

    // R10 software reset
    send(cw(1'b1, 1'b1, 0, 0, 8'h80));
    check(cra_o == 8'h00, "R10", "soft reset clears mode", cra_o, 0);

    // R7/R8 slot sweep in pure data mode, R6 lock
    for (int s = 0; s < 8; s++) begin
      int d0, f0, w0;
      hw_reset();
      send(cw(1'b1, 1'b1, 0, 0, (s << 2) | 1));
      check(cra_o == 8'((s << 2) | 1), "R6", "enter data mode", cra_o, (s << 2) | 1);
      tick();
      d0 = n_dac;
      for (int k = 0; k < 10; k++) send(16'h4000 | (s << 8) | k);
      check(n_dac == d0 + 1, "R8", "one capture in ten frames", n_dac - d0, 1);
      check(last_dac == 16'(16'h4000 | (s << 8) | s), "R7", "captured frame",
            last_dac, 16'h4000 | (s << 8) | s);
      f0 = n_fwd; w0 = n_we;
      send(cw(1'b1, 1'b1, 0, 0, 8'h00));
      send(cw(1'b1, 1'b1, 3, 2, 8'h44));
      send(cw(1'b1, 1'b1, 0, 4, 8'h44));
      send(NOP);
      check(cra_o == 8'((s << 2) | 1) && n_fwd == f0 && n_we == w0, "R6",
            "control ignored in data mode", cra_o, (s << 2) | 1);
    end

    // R7 frame index restarts at tick
    begin
      int d0;
      hw_reset();
      send(cw(1'b1, 1'b1, 0, 0, (1 << 2) | 1));
      tick();
      send(16'h1111);
      tick();
      d0 = n_dac;
      send(16'h2220);
      send(16'h2221);
      check(n_dac == d0 + 1 && last_dac == 16'h2221, "R7", "count restarts on tick",
            last_dac, 16'h2221);
    end

    // R9 mixed mode
    begin
      int d0, w0;
      hw_reset();
      send(cw(1'b1, 1'b1, 0, 0, (2 << 2) | 3));
      tick();
      d0 = n_dac; w0 = n_we;
      send(16'h0aa0);
      send(cw(1'b1, 1'b1, 0, 3, 8'h5a));
      send(16'h0aa2);
      check(n_we == w0 + 1 && last_wa == 3'd3 && last_wd == 8'h5a, "R9",
            "control in mixed mode", last_wd, 8'h5a);
      check(n_dac == d0 + 1 && last_dac == 16'h0aa2, "R9", "data slot in mixed mode",
            last_dac, 16'h0aa2);
      send(cw(1'b1, 1'b1, 0, 0, 8'h00));
      check(cra_o == 8'h00, "R9", "mixed mode allows reprogramming", cra_o, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule